// File: doc/BRIEF.md
# Chained Multi-Byte Subtract and Compare Unit

This block is an 8-bit subtract/compare slice with a five-bit status word. Every cycle it can take two operand bytes, a two-bit operation code and an incoming status word. At the next rising clock edge it presents the difference byte and the updated status. Wider numbers are handled one byte at a time, least significant byte first. The surrounding logic feeds the status output of one operation back as the status input of the next.

There are four operations: plain subtract, subtract with borrow, plain compare, and compare with borrow. The borrow forms subtract the incoming carry bit as well as the second operand. They also carry the zero indication forward across bytes: a multi-byte result reads as zero only when every byte was zero.

A 32-bit compare takes four back-to-back operations: a plain compare on the lowest byte, then three compare-with-borrow operations. The final status then shows five conditions:
- equal
- unsigned higher
- unsigned lower
- signed greater
- signed less

Compare operations update the status but never write the difference out.

Top module: `chainAluSlice`

## Requirements
- R1: An operation presented with `opValid` high at a rising edge drives its result and status onto the outputs at that same edge, so they are readable one clock after the operands were applied.
- R2: Operation codes are: 0 plain subtract, 1 subtract with borrow, 2 plain compare, 3 compare with borrow. Bit 0 selects the borrow form and bit 1 selects compare. The difference is `opA - opB - cin` modulo 256, where `cin` is status bit 0 for the borrow forms and 0 otherwise.
- R3: Status bit 0 (carry) is set exactly when the unsigned difference `opA - opB - cin` is negative, so it acts as a borrow.
- R4: For plain subtract and plain compare, status bit 1 (zero) is set exactly when the 8-bit difference is zero.
- R5: For the borrow forms, status bit 1 is set only when the 8-bit difference is zero and incoming status bit 1 was set. A nonzero difference clears it; a zero difference leaves it at its incoming value.
- R6: Status bit 2 (negative) equals bit 7 of the difference. Status bit 3 (overflow) is set when the operands' bit 7 differ and the difference's bit 7 differs from that of `opA`.
- R7: Status bit 4 (sign) equals the true sign of the signed difference, which is negative XOR overflow.
- R8: Subtract operations drive `resultWe` high and place the difference on `resultOut`. Compare operations drive `resultWe` low and leave `resultOut` unchanged.
- R9: A cycle with `opValid` low drives `resultWe` low and leaves `resultOut` and `statusOut` unchanged.
- R10: While `rstN` is low, `resultOut`, `resultWe` and `statusOut` are all zero.
- R11: After one plain compare and three chained compare-with-borrow operations on a 32-bit pair, the final status gives the following, in four cycles:
  - equal: Z=1
  - unsigned lower: C=1
  - unsigned higher: C=0 and Z=0
  - signed less: S=1
  - signed greater: S=0 and Z=0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 2 | Operation select (see R2) |
| opA | input | 8 | First operand (minuend) |
| opB | input | 8 | Second operand (subtrahend) |
| statusIn | input | 5 | Incoming status {S,V,N,Z,C} |
| resultOut | output | 8 | Registered difference byte |
| resultWe | output | 1 | Write-back strobe for the difference |
| statusOut | output | 5 | Registered updated status {S,V,N,Z,C} |

## Verification
The hardest case is a high byte that is zero after a nonzero low byte. The E104 minus E101 case is the example. A design that set zero from the current byte alone would report the whole 16-bit result as zero. The bench also drives the borrow forms with incoming zero clear, with incoming zero set, and with incoming carry both set and clear. A design that ignored the incoming carry, or forced zero high, would then give wrong bytes or wrong equality.

The 32-bit compares cover several pairs:
- equal pairs
- pairs that differ only in the lowest byte
- pairs that straddle the signed/unsigned boundary, such as 0x80000000 against 0x7FFFFFFF

On these pairs, a mistaken overflow or sign term gives the wrong signed answer while the unsigned answer stays correct.

Idle cycles and compares placed right after subtracts show any design that writes back or disturbs the status when it should hold.

// File: rtl/chainAluPkg.sv
package chainAluPkg;

  typedef enum logic [1:0] {
    OP_SUB = 2'b00,
    OP_SBC = 2'b01,
    OP_CMP = 2'b10,
    OP_CPC = 2'b11
  } aluOp_e;

  localparam int STATUS_W = 5;
  localparam int ST_C = 0;
  localparam int ST_Z = 1;
  localparam int ST_N = 2;
  localparam int ST_V = 3;
  localparam int ST_S = 4;

  typedef struct packed {
    logic update;
    logic subCarry;
    logic chainZero;
    logic writeBack;
  } aluStrobe_t;

endpackage

// File: rtl/chainAluCtrl.sv
module chainAluCtrl
  import chainAluPkg::*;
(
  input  logic       opValid,
  input  logic [1:0] opCode,
  output aluStrobe_t strobe
);

  aluOp_e op;

  always_comb begin
    op = aluOp_e'(opCode);
    strobe = '0;
    strobe.update = opValid;
    if (opValid) begin
      unique case (op)
        OP_SUB: strobe.writeBack = 1'b1;
        OP_SBC: begin
          strobe.writeBack = 1'b1;
          strobe.subCarry  = 1'b1;
          strobe.chainZero = 1'b1;
        end
        OP_CMP: ;
        OP_CPC: begin
          strobe.subCarry  = 1'b1;
          strobe.chainZero = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/chainAluDatapath.sv
module chainAluDatapath
  import chainAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  aluStrobe_t          strobe,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [STATUS_W-1:0] statusIn,
  output logic [DATA_W-1:0]   resultOut,
  output logic                resultWe,
  output logic [STATUS_W-1:0] statusOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]       diffWide;
  logic [DATA_W-1:0]     diff;
  logic                  carryIn;
  logic                  byteZero;
  logic [STATUS_W-1:0]   statusNext;

  always_comb begin
    carryIn  = strobe.subCarry & statusIn[ST_C];
    diffWide = {1'b0, opA} - {1'b0, opB} - {{DATA_W{1'b0}}, carryIn};
    diff     = diffWide[DATA_W-1:0];
    byteZero = (diff == '0);

    statusNext       = '0;
    statusNext[ST_C] = diffWide[DATA_W];
    statusNext[ST_Z] = strobe.chainZero ? (byteZero & statusIn[ST_Z]) : byteZero;
    statusNext[ST_N] = diff[MSB];
    statusNext[ST_V] = (opA[MSB] ^ opB[MSB]) & (diff[MSB] ^ opA[MSB]);
    statusNext[ST_S] = statusNext[ST_N] ^ statusNext[ST_V];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
      resultWe  <= 1'b0;
      statusOut <= '0;
    end else begin
      resultWe <= strobe.writeBack;
      if (strobe.update) begin
        statusOut <= statusNext;
      end
      if (strobe.writeBack) begin
        resultOut <= diff;
      end
    end
  end

endmodule

// File: rtl/chainAluSlice.sv
module chainAluSlice
  import chainAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [1:0]          opCode,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [STATUS_W-1:0] statusIn,
  output logic [DATA_W-1:0]   resultOut,
  output logic                resultWe,
  output logic [STATUS_W-1:0] statusOut
);

  aluStrobe_t strobe;

  chainAluCtrl u_ctrl (
    .opValid(opValid),
    .opCode (opCode),
    .strobe (strobe)
  );

  chainAluDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .statusIn (statusIn),
    .resultOut(resultOut),
    .resultWe (resultWe),
    .statusOut(statusOut)
  );

endmodule

// File: rtl/chainAluChecker.sv
module chainAluChecker
  import chainAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                opValid,
  input logic [1:0]          opCode,
  input logic [DATA_W-1:0]   opA,
  input logic [DATA_W-1:0]   opB,
  input logic [STATUS_W-1:0] statusIn,
  input logic [DATA_W-1:0]   resultOut,
  input logic                resultWe,
  input logic [STATUS_W-1:0] statusOut
);

  assert_sub_result_R1: assert property (@(posedge clk) disable iff (!rstN)
    opValid && !opCode[1] |=> resultWe &&
      resultOut == DATA_W'($past(opA) - $past(opB) -
                           DATA_W'($past(opCode[0]) & $past(statusIn[ST_C]))));

  assert_borrow_R3: assert property (@(posedge clk) disable iff (!rstN)
    opValid && !opCode[0] && (opA < opB) |=> statusOut[ST_C]);

  assert_zero_plain_R4: assert property (@(posedge clk) disable iff (!rstN)
    opValid && !opCode[0] && (opA == opB) |=> statusOut[ST_Z]);

  assert_zero_chain_R5: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode[0] && !statusIn[ST_Z] |=> !statusOut[ST_Z]);

  assert_cmp_nowrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode[1] |=> !resultWe && $stable(resultOut));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resultWe && $stable(statusOut) && $stable(resultOut));

endmodule

bind chainAluSlice chainAluChecker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .opA      (opA),
  .opB      (opB),
  .statusIn (statusIn),
  .resultOut(resultOut),
  .resultWe (resultWe),
  .statusOut(statusOut)
);

// File: tb/tb_chainAluSlice.sv
module tb_chainAluSlice;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [1:0] opCode = 2'd0;
  logic [7:0] opA = 8'd0;
  logic [7:0] opB = 8'd0;
  logic [4:0] statusIn = 5'd0;
  logic [7:0] resultOut;
  logic       resultWe;
  logic [4:0] statusOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] expRes = 8'd0;
  logic       expWe = 1'b0;
  logic [4:0] expSt = 5'd0;

  always #4 clk = ~clk;

  chainAluSlice dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .statusIn(statusIn),
    .resultOut(resultOut), .resultWe(resultWe), .statusOut(statusOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Called just after a falling edge; applies one cycle and checks outputs.
  task automatic doOp(input int a, input int b, input logic [1:0] op,
                      input bit chain, input logic [4:0] sGiven, input bit valid);
    logic [4:0] sEff;
    int cin, d, r, sa, sb, sd;
    sEff = chain ? statusOut : sGiven;
    opValid = valid; opCode = op; opA = a[7:0]; opB = b[7:0]; statusIn = sEff;
    if (valid) begin
      cin = op[0] ? int'(sEff[0]) : 0;
      d = a - b - cin;
      r = d & 255;
      sa = (a >= 128) ? a - 256 : a;
      sb = (b >= 128) ? b - 256 : b;
      sd = sa - sb - cin;
      expSt[0] = (d < 0);
      expSt[1] = (r == 0) && (op[0] ? sEff[1] : 1'b1);
      expSt[2] = (r >= 128);
      expSt[3] = (sd < -128) || (sd > 127);
      expSt[4] = (sd < 0);
      expWe = !op[1];
      if (!op[1]) expRes = r[7:0];
    end else begin
      expWe = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(valid ? "R2/R1 result" : "R9 result hold", resultOut, expRes);
    check(valid ? "R8 write strobe" : "R9 write strobe", resultWe, expWe);
    check("R3 carry", statusOut[0], expSt[0]);
    check(op[0] ? "R5 chained zero" : "R4 zero", statusOut[1], expSt[1]);
    check("R6 negative/overflow", statusOut[3:2], expSt[3:2]);
    check("R7 sign", statusOut[4], expSt[4]);
    opValid = 1'b0;
  endtask

  task automatic cmp32(input logic [31:0] x, input logic [31:0] y);
    doOp(x[7:0], y[7:0], 2'd2, 0, 5'b00010, 1);
    for (int i = 1; i < 4; i++)
      doOp(x[8*i +: 8], y[8*i +: 8], 2'd3, 1, 5'd0, 1);
    check("R11 equal", statusOut[1], x == y);
    check("R11 unsigned lower", statusOut[0], x < y);
    check("R11 unsigned higher", !statusOut[0] && !statusOut[1], x > y);
    check("R11 signed less", statusOut[4], $signed(x) < $signed(y));
    check("R11 signed greater", !statusOut[4] && !statusOut[1], $signed(x) > $signed(y));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset result", resultOut, 0);
    check("R10 reset strobe", resultWe, 0);
    check("R10 reset status", statusOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5: E104 - E101, low byte then high byte; high byte zero must not set Z
    doOp(8'h04, 8'h01, 2'd0, 0, 5'd0, 1);
    doOp(8'hE1, 8'hE1, 2'd1, 1, 5'd0, 1);
    check("R5 16-bit high byte", resultOut, 8'h00);
    check("R5 16-bit zero clear", statusOut[1], 0);
    // zero-zero chain keeps Z set
    doOp(8'h10, 8'h10, 2'd0, 0, 5'd0, 1);
    doOp(8'h22, 8'h22, 2'd1, 1, 5'd0, 1);
    check("R5 16-bit zero kept", statusOut[1], 1);
    // borrow propagates (0x0100 - 0x0001 = 0x00FF)
    doOp(8'h00, 8'h01, 2'd0, 0, 5'd0, 1);
    doOp(8'h01, 8'h00, 2'd1, 1, 5'd0, 1);
    check("R3 borrow propagated", resultOut, 8'h00);
    // compare after subtract leaves result, then idle cycles
    doOp(8'h55, 8'h12, 2'd0, 0, 5'd0, 1);
    doOp(8'h01, 8'hFF, 2'd2, 0, 5'd0, 1);
    doOp(8'h77, 8'h33, 2'd3, 0, 5'b00011, 0);
    doOp(8'h77, 8'h33, 2'd0, 0, 5'd0, 0);
    // overflow corners
    doOp(8'h80, 8'h01, 2'd0, 0, 5'd0, 1);
    doOp(8'h7F, 8'hFF, 2'd2, 0, 5'd0, 1);
    doOp(8'h00, 8'h00, 2'd1, 0, 5'b00001, 1);
    doOp(8'h05, 8'h04, 2'd3, 0, 5'b00011, 1);

    cmp32(32'h12345678, 32'h12345678);
    cmp32(32'h12345679, 32'h12345678);
    cmp32(32'h12345678, 32'h12345679);
    cmp32(32'h80000000, 32'h7FFFFFFF);
    cmp32(32'h7FFFFFFF, 32'h80000000);
    cmp32(32'hFFFFFFFF, 32'h00000000);
    cmp32(32'h00000000, 32'h00000000);
    cmp32(32'hE1040000, 32'hE1010000);

    for (int k = 0; k < 300; k++) begin
      int a, b;
      a = $urandom_range(255);
      b = ($urandom_range(3) == 0) ? a : $urandom_range(255);
      doOp(a, b, 2'($urandom_range(3)), bit'($urandom_range(1)),
           5'($urandom_range(31)), ($urandom_range(7) != 0));
    end
    for (int k = 0; k < 20; k++)
      cmp32($urandom(), ($urandom_range(3) == 0) ? 32'h0 : $urandom());

    summary();
  end

endmodule